// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and a flash-style memory and decides what the part does from byte-wide command writes. Each write with `wr_en` high carries an opcode on `wr_data` and an address on `wr_addr`. The block moves between array read, identifier read and status read. It accepts a two-write erase unlock, starts an external erase engine, and can freeze and restart that erase through a suspend handshake. It drives a ready/busy pin that the host can poll.

Reads are a one-way stream. A read request on `rd_en` with `rd_addr` produces exactly one result one cycle later on `rd_valid`, together with `rd_src` and `rd_data`. The result stream has no back-pressure, so the consumer must take every result in the cycle it is presented. When `rd_src` is array, the host takes data from the memory array and `rd_data` is zero. The erase engine connects through `ers_start`, `ers_suspend` and `ers_resume`, and reports back on `eng_suspended` and `eng_done`. These pins are plain control signals.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read source is array, `ry_by` is 1, no engine request is active, and the status byte reads 80h.
- R2: Writing FFh in an idle mode selects array reads: `rd_src` = 2'b00 and `rd_data` = 00h.
- R3: Writing 90h selects identifier reads with `rd_src` = 2'b01. Address 0 returns 89h, address 1 returns A2h, and any other address returns 00h. The mode stays in force over any number of reads.
- R4: Writing 70h selects status reads with `rd_src` = 2'b10. The status byte is: bit7 ready, bit6 erase suspended, bit5 erase error, bit4 command-sequence error, bit3 high-voltage error, and bits 2..0 zero.
- R5: Writing 20h and then D0h with `vpp_ok` high starts an erase. `ers_start` pulses for one cycle, in the cycle after the D0h write. `ers_addr` holds the address of the D0h write. `ry_by` drops to 0, and reads return status.
- R6: If `vpp_ok` is low when D0h confirms an erase, no start is issued, status bits 5 and 3 are set, `ry_by` stays 1, and reads return status.
- R7: Any byte other than D0h after 20h aborts the sequence. It sets status bits 5 and 4, issues no start, and selects status reads.
- R8: While an erase runs, every write except B0h is ignored. The read source stays status and no further start is issued.
- R9: Writing B0h during an erase raises `ers_suspend` in the next cycle. Until `eng_suspended` is reported, `ry_by` and status bit6 stay 0. Once it is reported, `ry_by` and status bits 7 and 6 become 1.
- R10: While suspended, FFh selects array reads, 70h selects status reads, and all other opcodes except D0h are ignored. D0h pulses `ers_resume`, drops `ers_suspend`, drives `ry_by` to 0 and selects status reads.
- R11: On `eng_done` the erase ends. `ry_by` returns to 1, status bit7 reads 1, and reads stay on status.
- R12: Error bits 5, 4 and 3 are sticky. Only 50h, written in an idle mode, clears them, and it leaves the read source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | ADDR_W | Address of the command write |
| wr_data | input | 8 | Command opcode |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| vpp_ok | input | 1 | High voltage present |
| eng_suspended | input | 1 | Erase engine is frozen at a safe point |
| eng_done | input | 1 | Erase engine finished (one-cycle pulse) |
| ers_start | output | 1 | Start-erase pulse |
| ers_suspend | output | 1 | Suspend request level |
| ers_resume | output | 1 | Resume pulse |
| ers_addr | output | ADDR_W | Latched confirm address of the block to erase |
| ry_by | output | 1 | Ready (1) / busy (0) |
| rd_valid | output | 1 | Read result valid |
| rd_src | output | 2 | Read source: 00 array, 01 identifier, 10 status |
| rd_data | output | 8 | Identifier or status byte |

## Verification
The assertions assume that the engine reports `eng_done` only while an erase is running. They also assume that it raises `eng_suspended` only while `ers_suspend` is high, and that `vpp_ok` is stable around a confirm write. The bench's engine model is a countdown. It starts only on `ers_start`, freezes a few cycles after `ers_suspend` rises, and releases when that request drops. This keeps every handshake in the order the block expects. The bench drives each command write and each read as a single-cycle strobe, away from the clock edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_READ    = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_SETUP   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;

  localparam logic [7:0] ID_MAKER  = 8'h89;
  localparam logic [7:0] ID_DEVICE = 8'hA2;

  typedef enum logic [2:0] {
    C_READ, C_IDENT, C_STATUS, C_CLEAR, C_SETUP, C_CONFIRM, C_SUSPEND, C_OTHER
  } cmd_e;

  typedef enum logic [2:0] {
    M_ARRAY, M_IDENT, M_STATUS, M_SETUP, M_ERASE, M_SUSP_REQ, M_SUSP
  } mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'b00, SRC_IDENT = 2'b01, SRC_STATUS = 2'b10
  } src_e;

  typedef struct packed {
    logic erase;
    logic seq;
    logic vpp;
  } err_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_e       cmd
);
  always_comb begin
    unique case (opcode)
      OP_READ:    cmd = C_READ;
      OP_IDENT:   cmd = C_IDENT;
      OP_STATUS:  cmd = C_STATUS;
      OP_CLEAR:   cmd = C_CLEAR;
      OP_SETUP:   cmd = C_SETUP;
      OP_CONFIRM: cmd = C_CONFIRM;
      OP_SUSPEND: cmd = C_SUSPEND;
      default:    cmd = C_OTHER;
    endcase
  end
endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              vpp_ok,
  input  logic              eng_suspended,
  input  logic              eng_done,
  output src_e              src,
  output logic              ready,
  output logic              suspended,
  output logic              start,
  output logic              resume,
  output logic              susp_req,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              set_erase,
  output logic              set_seq,
  output logic              set_vpp,
  output logic              clr_err
);
  mode_e mode;
  src_e  susp_view;
  logic  idle;
  logic  in_setup_wr;
  logic  go;

  assign idle        = (mode == M_ARRAY) || (mode == M_IDENT) || (mode == M_STATUS);
  assign in_setup_wr = (mode == M_SETUP) && wr_en;
  assign go          = in_setup_wr && (cmd == C_CONFIRM) && vpp_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_ARRAY;
      susp_view <= SRC_STATUS;
      start     <= 1'b0;
      resume    <= 1'b0;
      blk_addr  <= '0;
    end else begin
      start  <= 1'b0;
      resume <= 1'b0;
      unique case (mode)
        M_ARRAY, M_IDENT, M_STATUS: begin
          if (wr_en) begin
            case (cmd)
              C_READ:   mode <= M_ARRAY;
              C_IDENT:  mode <= M_IDENT;
              C_STATUS: mode <= M_STATUS;
              C_SETUP:  mode <= M_SETUP;
              default:  mode <= mode;
            endcase
          end
        end
        M_SETUP: begin
          if (wr_en) begin
            if (go) begin
              mode     <= M_ERASE;
              start    <= 1'b1;
              blk_addr <= wr_addr;
            end else begin
              mode <= M_STATUS;
            end
          end
        end
        M_ERASE: begin
          if (eng_done) mode <= M_STATUS;
          else if (wr_en && cmd == C_SUSPEND) mode <= M_SUSP_REQ;
        end
        M_SUSP_REQ: begin
          if (eng_done) mode <= M_STATUS;
          else if (eng_suspended) begin
            mode      <= M_SUSP;
            susp_view <= SRC_STATUS;
          end
        end
        M_SUSP: begin
          if (wr_en) begin
            case (cmd)
              C_READ:   susp_view <= SRC_ARRAY;
              C_STATUS: susp_view <= SRC_STATUS;
              C_CONFIRM: begin
                mode   <= M_ERASE;
                resume <= 1'b1;
              end
              default: susp_view <= susp_view;
            endcase
          end
        end
        default: mode <= M_ARRAY;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      M_ARRAY: src = SRC_ARRAY;
      M_IDENT: src = SRC_IDENT;
      M_SUSP:  src = susp_view;
      default: src = SRC_STATUS;
    endcase
  end

  assign ready     = !((mode == M_ERASE) || (mode == M_SUSP_REQ));
  assign suspended = (mode == M_SUSP);
  assign susp_req  = (mode == M_SUSP_REQ) || (mode == M_SUSP);
  assign set_vpp   = in_setup_wr && (cmd == C_CONFIRM) && !vpp_ok;
  assign set_seq   = in_setup_wr && (cmd != C_CONFIRM);
  assign set_erase = in_setup_wr && !go;
  assign clr_err   = idle && wr_en && (cmd == C_CLEAR);

  // R8: no start is issued unless the previous cycle held a confirm write
  p_start_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(wr_en));

  // R10: start and resume never coincide
  p_start_resume_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && resume));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_erase,
  input  logic set_seq,
  input  logic set_vpp,
  input  logic clr_err,
  output err_t err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= '0;
    end else if (clr_err) begin
      err <= '0;
    end else begin
      if (set_erase) err.erase <= 1'b1;
      if (set_seq)   err.seq   <= 1'b1;
      if (set_vpp)   err.vpp   <= 1'b1;
    end
  end

  // R12: error bits never drop without a clear command
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_err) |-> ((err & $past(err)) == $past(err)));
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  src_e              src,
  input  logic              ready,
  input  logic              suspended,
  input  err_t              err,
  output logic              rd_valid,
  output logic [1:0]        rd_src,
  output logic [7:0]        rd_data
);
  logic [7:0] status_byte;
  logic [7:0] ident_byte;

  assign status_byte = {ready, suspended, err.erase, err.seq, err.vpp, 3'b000};

  always_comb begin
    if (rd_addr == ADDR_W'(0))      ident_byte = ID_MAKER;
    else if (rd_addr == ADDR_W'(1)) ident_byte = ID_DEVICE;
    else                            ident_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_src   <= SRC_ARRAY;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_src <= src;
        unique case (src)
          SRC_IDENT:  rd_data <= ident_byte;
          SRC_STATUS: rd_data <= status_byte;
          default:    rd_data <= 8'h00;
        endcase
      end
    end
  end

  // R3: an identifier result only ever carries one of the three defined codes
  p_ident_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_src == SRC_IDENT) |->
      (rd_data == ID_MAKER || rd_data == ID_DEVICE || rd_data == 8'h00));

  // R2: array results carry zero data
  p_array_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_src == SRC_ARRAY) |-> (rd_data == 8'h00));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              vpp_ok,
  input  logic              eng_suspended,
  input  logic              eng_done,
  output logic              ers_start,
  output logic              ers_suspend,
  output logic              ers_resume,
  output logic [ADDR_W-1:0] ers_addr,
  output logic              ry_by,
  output logic              rd_valid,
  output logic [1:0]        rd_src,
  output logic [7:0]        rd_data
);
  cmd_e cmd;
  src_e src;
  err_t err;
  logic ready, suspended;
  logic set_erase, set_seq, set_vpp, clr_err;

  flash_cmd_decode u_dec (
    .opcode (wr_data),
    .cmd    (cmd)
  );

  flash_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .cmd           (cmd),
    .wr_addr       (wr_addr),
    .vpp_ok        (vpp_ok),
    .eng_suspended (eng_suspended),
    .eng_done      (eng_done),
    .src           (src),
    .ready         (ready),
    .suspended     (suspended),
    .start         (ers_start),
    .resume        (ers_resume),
    .susp_req      (ers_suspend),
    .blk_addr      (ers_addr),
    .set_erase     (set_erase),
    .set_seq       (set_seq),
    .set_vpp       (set_vpp),
    .clr_err       (clr_err)
  );

  flash_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_erase (set_erase),
    .set_seq   (set_seq),
    .set_vpp   (set_vpp),
    .clr_err   (clr_err),
    .err       (err)
  );

  flash_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .src       (src),
    .ready     (ready),
    .suspended (suspended),
    .err       (err),
    .rd_valid  (rd_valid),
    .rd_src    (rd_src),
    .rd_data   (rd_data)
  );

  assign ry_by = ready;

  // R5: a start only follows a confirm made with high voltage, and busy is shown at once
  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ers_start |-> ($past(vpp_ok) && !ry_by));

  // R10: the suspend request only drops on resume or on completion
  p_suspend_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ers_suspend) |-> (ers_resume || $past(eng_done)));

  // R9: ready while a suspend is requested means the engine has frozen
  p_ready_when_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ry_by) && ers_suspend) |-> $past(eng_suspended));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int ERS_LEN    = 80;
  localparam int SUSP_LAT   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = 8'h00;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              vpp_ok = 1'b1;
  logic              eng_suspended;
  logic              eng_done;
  logic              ers_start, ers_suspend, ers_resume, ry_by;
  logic [ADDR_W-1:0] ers_addr;
  logic              rd_valid;
  logic [1:0]        rd_src;
  logic [7:0]        rd_data;

  int checks = 0;
  int fails  = 0;
  int starts = 0;

  typedef struct { logic [1:0] src; logic [7:0] data; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .vpp_ok(vpp_ok),
    .eng_suspended(eng_suspended), .eng_done(eng_done),
    .ers_start(ers_start), .ers_suspend(ers_suspend), .ers_resume(ers_resume),
    .ers_addr(ers_addr), .ry_by(ry_by), .rd_valid(rd_valid), .rd_src(rd_src),
    .rd_data(rd_data)
  );

  // erase engine model: countdown that freezes while a suspend is requested
  logic       eng_busy;
  int         eng_cnt;
  int         lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_busy <= 1'b0; eng_cnt <= 0; lat_cnt <= 0;
      eng_suspended <= 1'b0; eng_done <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (ers_start) begin
        eng_busy <= 1'b1; eng_cnt <= ERS_LEN; lat_cnt <= 0;
      end else if (eng_busy) begin
        if (ers_suspend) begin
          if (lat_cnt < SUSP_LAT) lat_cnt <= lat_cnt + 1;
          else eng_suspended <= 1'b1;
        end else begin
          eng_suspended <= 1'b0;
          lat_cnt <= 0;
          if (eng_cnt == 0) begin
            eng_busy <= 1'b0; eng_done <= 1'b1;
          end else eng_cnt <= eng_cnt - 1;
        end
      end
    end
  end

  always @(posedge clk) if (rst_n && ers_start) starts++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] op, input logic [ADDR_W-1:0] a = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = op; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                    input logic [7:0] d, input string tag);
    exp_t e;
    e.src = s; e.data = d; e.tag = tag;
    sb.push_back(e);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected read result: actual %0h expected none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " src"},  {30'd0, rd_src}, {30'd0, e.src});
        check({e.tag, " data"}, {24'd0, rd_data}, {24'd0, e.data});
      end
    end
  end

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!ry_by && n < 1000) begin @(negedge clk); n++; end
    check({tag, " ready reached"}, {31'd0, ry_by}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ry_by", {31'd0, ry_by}, 32'd1);
    check("R1 ers_start", {31'd0, ers_start}, 32'd0);
    check("R1 ers_suspend", {31'd0, ers_suspend}, 32'd0);
    rd(0, 2'b00, 8'h00, "R1 reset array");
    wr(8'h70);
    rd(0, 2'b10, 8'h80, "R1 R4 status after reset");

    // R3 identifier
    wr(8'h90);
    rd(0, 2'b01, 8'h89, "R3 maker");
    rd(1, 2'b01, 8'hA2, "R3 device");
    rd(5, 2'b01, 8'h00, "R3 other");
    rd(0, 2'b01, 8'h89, "R3 held");

    // R2 array
    wr(8'hFF);
    rd(1, 2'b00, 8'h00, "R2 array");

    // R6 low voltage confirm
    vpp_ok = 1'b0;
    wr(8'h20); wr(8'hD0, 20'h30000);
    check("R6 ry_by", {31'd0, ry_by}, 32'd1);
    rd(0, 2'b10, 8'hA8, "R6 vpp error");
    vpp_ok = 1'b1;

    // R12 clear, and read source unchanged
    wr(8'h50);
    rd(0, 2'b10, 8'h80, "R12 cleared");
    check("R6 no start", starts, 0);

    // R7 broken sequence
    wr(8'hFF);
    wr(8'h20); wr(8'h40);
    rd(0, 2'b10, 8'hB0, "R7 seq error");
    wr(8'h90);
    rd(0, 2'b01, 8'h89, "R12 sticky not on src change");
    wr(8'h70);
    rd(0, 2'b10, 8'hB0, "R12 sticky");
    wr(8'h50);
    rd(0, 2'b10, 8'h80, "R12 clear again");
    check("R7 no start", starts, 0);

    // R5 real erase
    wr(8'h20);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hD0; wr_addr = 20'h5ABCD;
    @(negedge clk); wr_en = 1'b0;
    check("R5 start pulse", {31'd0, ers_start}, 32'd1);
    check("R5 addr", {12'd0, ers_addr}, 32'h5ABCD);
    check("R5 busy", {31'd0, ry_by}, 32'd0);
    rd(0, 2'b10, 8'h00, "R5 status busy");
    check("R5 single pulse", {31'd0, ers_start}, 32'd0);

    // R8 ignored commands
    wr(8'hFF); wr(8'h90); wr(8'h20); wr(8'hD0); wr(8'h50);
    rd(0, 2'b10, 8'h00, "R8 ignored");
    check("R8 start count", starts, 1);

    // R9 suspend
    wr(8'hB0);
    check("R9 suspend req", {31'd0, ers_suspend}, 32'd1);
    check("R9 still busy", {31'd0, ry_by}, 32'd0);
    rd(0, 2'b10, 8'h00, "R9 pending status");
    wait_ready("R9");
    rd(0, 2'b10, 8'hC0, "R9 suspended status");

    // R10 suspended commands
    wr(8'hFF);
    rd(0, 2'b00, 8'h00, "R10 array in suspend");
    wr(8'h90);
    rd(0, 2'b00, 8'h00, "R10 ident ignored");
    wr(8'h20);
    rd(0, 2'b00, 8'h00, "R10 setup ignored");
    wr(8'h70);
    rd(0, 2'b10, 8'hC0, "R10 status in suspend");
    wr(8'hD0);
    check("R10 resume pulse", {31'd0, ers_resume}, 32'd1);
    check("R10 suspend dropped", {31'd0, ers_suspend}, 32'd0);
    check("R10 busy", {31'd0, ry_by}, 32'd0);
    rd(0, 2'b10, 8'h00, "R10 status after resume");

    // R11 completion
    wait_ready("R11");
    rd(0, 2'b10, 8'h80, "R11 done status");
    check("R11 start count", starts, 1);
    wr(8'hFF);
    rd(0, 2'b00, 8'h00, "R11 R2 array after erase");

    repeat (4) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule